// File: doc/BRIEF.md
# Double-buffered UART transmitter

This block serialises bytes onto an asynchronous serial line. Software writes a character into a one-deep holding buffer. The transmitter moves that character into its shift register as soon as the shifter is free. It then sends a start bit, 7 or 8 data bits with the least significant bit first, an optional parity bit and one or two stop bits. Every bit lasts 16 pulses of a baud tick input. The tick is divided down by an internal counter, and that counter is held at zero whenever the line is idle.

Two status outputs let software pace itself. `buf_empty` says the holding buffer can take another byte. `shift_done` says the last frame has reached the middle of its final stop bit. A byte that is already waiting when a frame ends is sent with no idle time between the two frames. An interrupt request can be raised either when a byte moves from the buffer into the shifter or when a frame completes. Software clears it with a one-cycle pulse.

Top module: `sertx_core`

## Requirements
- R1: After reset, `txd` = 1, `buf_empty` = 1, `shift_done` = 1 and `irq_req` = 0.
- R2: A `tx_we` pulse makes `buf_empty` 0 from the next cycle. When the line is idle, the byte moves to the shifter one cycle later. In that same cycle `buf_empty` returns to 1 and `txd` drops to 0 for the start bit.
- R3: A frame begins with a start bit of 0, followed by the data bits with the least significant bit first. There are 8 data bits when `cfg_char8` = 1 and 7 when it is 0; in the 7-bit case data bit 7 is not sent. Each bit lasts 16 `baud_tick` pulses.
- R4: With `cfg_par_en` = 1, a parity bit follows the data bits. With `cfg_par_odd` = 0 the total count of ones in the data bits plus parity is even; with `cfg_par_odd` = 1 it is odd.
- R5: Stop bits are 1. There is one stop bit when `cfg_stop2` = 0 and two when it is 1.
- R6: `shift_done` falls when the first data bit is driven. It rises at the 8th tick of the final stop bit.
- R7: A byte waiting in the buffer when the final stop bit ends starts its start bit in that same cycle, with no idle cycle. Otherwise the line returns high and the tick divider is held at zero until the next load.
- R8: With `cfg_irq_done` = 0, `irq_req` is set when a byte moves from the buffer into the shifter. With `cfg_irq_done` = 1, it is set when `shift_done` rises.
- R9: An `irq_clr` pulse clears `irq_req`. A set event in the same cycle wins over the clear.
- R10: The character length, parity and stop settings are captured when a byte is loaded into the shifter. A `cfg_we` write during a frame therefore affects only later frames. The interrupt source selection takes effect immediately.
- R11: A write while the buffer is full, with no transfer in that cycle, replaces the buffered byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Oversampling tick, 16 per bit |
| cfg_we | input | 1 | Loads the configuration inputs |
| cfg_char8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_stop2 | input | 1 | 1: two stop bits, 0: one stop bit |
| cfg_irq_done | input | 1 | Interrupt source: 1 frame done, 0 buffer transfer |
| tx_we | input | 1 | Write strobe for the holding buffer |
| tx_wdata | input | 8 | Character to send |
| irq_clr | input | 1 | Clears the interrupt request |
| txd | output | 1 | Serial line, idles high |
| buf_empty | output | 1 | Holding buffer can accept a byte |
| shift_done | output | 1 | Last frame finished shifting |
| irq_req | output | 1 | Transmit interrupt request |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is an interrupt set and a software clear. The bench asserts `irq_clr` exactly on the edge where an idle transmitter loads its shifter. With the transfer-based source selected, the request must remain 1. With the completion-based source selected, the request must be 0.

The second pair is a buffer transfer and the end of a frame. The bench writes a byte during a frame, and sometimes overwrites it before the frame ends. It then checks that the last written byte's start bit appears on the very cycle the final stop bit ends, and that `buf_empty` returns to 1 in that same cycle.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  // Frame format and interrupt source settings held by the transmitter.
  typedef struct packed {
    logic char8;       // 1: long character, 0: short character
    logic par_en;      // append parity bit
    logic par_odd;     // 1: odd, 0: even
    logic stop2;       // 1: two stop bits
    logic irq_on_done; // 1: request on frame completion, 0: on buffer transfer
  } sertx_cfg_t;

  localparam sertx_cfg_t SERTX_CFG_RST = '{
    char8:       1'b1,
    par_en:      1'b0,
    par_odd:     1'b0,
    stop2:       1'b0,
    irq_on_done: 1'b0
  };

endpackage

// File: rtl/sertx_div16.sv
// Tick divider: one bit boundary every OVERSAMPLE ticks, one mid-bit strobe
// halfway through. The counter is forced to zero while the line is idle (R7).
module sertx_div16 #(
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic bit_edge,
  output logic mid_edge
);

  localparam int unsigned CW = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(OVERSAMPLE - 1);
  localparam logic [CW-1:0] CNT_MID  = CW'(OVERSAMPLE / 2 - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign bit_edge = run & tick & (cnt_q == CNT_LAST);
  assign mid_edge = run & tick & (cnt_q == CNT_MID);

endmodule

// File: rtl/sertx_frame_pack.sv
// Builds the complete frame, bit 0 first: start, data, parity, stop, padded
// with ones. Also returns the number of bits the frame holds (R3, R4, R5).
module sertx_frame_pack
  import sertx_pkg::*;
#(
  parameter int unsigned MAX_CHAR   = 8,
  parameter int unsigned SHORT_CHAR = 7,
  parameter int unsigned FRAME_W    = MAX_CHAR + 4,
  parameter int unsigned NB_W       = $clog2(FRAME_W + 1)
) (
  input  logic [MAX_CHAR-1:0] data,
  input  sertx_cfg_t          cfg,
  output logic [FRAME_W-1:0]  frame,
  output logic [NB_W-1:0]     nbits
);

  int                  char_len;
  logic [MAX_CHAR-1:0] data_m;
  logic [FRAME_W-1:0]  data_ext;
  logic                par_bit;

  always_comb begin
    char_len = cfg.char8 ? int'(MAX_CHAR) : int'(SHORT_CHAR);
    for (int i = 0; i < int'(MAX_CHAR); i++) begin
      data_m[i] = data[i] & (i < char_len);
    end
    data_ext = FRAME_W'(data_m);
    par_bit  = (^data_m) ^ cfg.par_odd;

    frame    = '1;
    frame[0] = 1'b0;
    for (int j = 1; j < int'(FRAME_W); j++) begin
      if (j <= char_len) begin
        frame[j] = data_ext[j-1];
      end else if (cfg.par_en && (j == char_len + 1)) begin
        frame[j] = par_bit;
      end
    end
    nbits = NB_W'(char_len + 2 + int'(cfg.par_en) + int'(cfg.stop2));
  end

endmodule

// File: rtl/sertx_txbuf.sv
// One-deep holding buffer. A write wins over a take in the same cycle, so a
// byte written while the old one leaves is kept (R2, R11).
module sertx_txbuf #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         take,
  output logic         full,
  output logic [W-1:0] data
);

  logic         full_d;
  logic [W-1:0] data_d;

  always_comb begin
    full_d = full;
    data_d = data;
    if (wr_en) begin
      full_d = 1'b1;
      data_d = wr_data;
    end else if (take) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      full <= full_d;
      data <= data_d;
    end
  end

endmodule

// File: rtl/sertx_core.sv
module sertx_core
  import sertx_pkg::*;
#(
  parameter int unsigned MAX_CHAR   = 8,
  parameter int unsigned SHORT_CHAR = 7,
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                baud_tick,
  input  logic                cfg_we,
  input  logic                cfg_char8,
  input  logic                cfg_par_en,
  input  logic                cfg_par_odd,
  input  logic                cfg_stop2,
  input  logic                cfg_irq_done,
  input  logic                tx_we,
  input  logic [MAX_CHAR-1:0] tx_wdata,
  input  logic                irq_clr,
  output logic                txd,
  output logic                buf_empty,
  output logic                shift_done,
  output logic                irq_req
);

  localparam int unsigned FRAME_W = MAX_CHAR + 4;
  localparam int unsigned NB_W    = $clog2(FRAME_W + 1);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_s = rst_sync_q[1];

  // Configuration register.
  sertx_cfg_t cfg_q;
  sertx_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we) begin
      cfg_d = '{char8: cfg_char8, par_en: cfg_par_en, par_odd: cfg_par_odd,
                stop2: cfg_stop2, irq_on_done: cfg_irq_done};
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cfg_q <= SERTX_CFG_RST;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  // Holding buffer.
  logic                buf_full;
  logic [MAX_CHAR-1:0] buf_data;
  logic                load;

  sertx_txbuf #(.W(MAX_CHAR)) buf_i (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (tx_we),
    .wr_data (tx_wdata),
    .take    (load),
    .full    (buf_full),
    .data    (buf_data)
  );

  // Frame assembly from the buffered byte and the current settings.
  logic [FRAME_W-1:0] frame_new;
  logic [NB_W-1:0]    nb_new;

  sertx_frame_pack #(
    .MAX_CHAR   (MAX_CHAR),
    .SHORT_CHAR (SHORT_CHAR),
    .FRAME_W    (FRAME_W),
    .NB_W       (NB_W)
  ) pack_i (
    .data  (buf_data),
    .cfg   (cfg_q),
    .frame (frame_new),
    .nbits (nb_new)
  );

  // Bit timing.
  logic running_q;
  logic bit_edge;
  logic mid_edge;

  sertx_div16 #(.OVERSAMPLE(OVERSAMPLE)) div_i (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .run      (running_q),
    .tick     (baud_tick),
    .bit_edge (bit_edge),
    .mid_edge (mid_edge)
  );

  // Shift sequencer.
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic [NB_W-1:0]    pos_q, pos_d;
  logic [NB_W-1:0]    nb_q, nb_d;
  logic               running_d;
  logic               done_q, done_d;
  logic               irq_q, irq_d;
  logic               at_last;
  logic               set_evt;

  assign at_last = (pos_q == nb_q - 1'b1);
  // R7: idle shifter loads at once; busy shifter loads exactly at frame end.
  assign load    = buf_full & (~running_q | (bit_edge & at_last));
  // R8: interrupt source selection is applied live.
  assign set_evt = cfg_q.irq_on_done ? (mid_edge & at_last) : load;

  always_comb begin
    running_d = running_q;
    frame_d   = frame_q;
    pos_d     = pos_q;
    nb_d      = nb_q;
    done_d    = done_q;
    irq_d     = irq_q;

    if (load) begin
      running_d = 1'b1;
      frame_d   = frame_new;
      pos_d     = '0;
      nb_d      = nb_new;
    end else if (bit_edge) begin
      if (at_last) begin
        running_d = 1'b0;
      end else begin
        frame_d = {1'b1, frame_q[FRAME_W-1:1]};
        pos_d   = pos_q + 1'b1;
      end
    end

    // R6: clear when the first data bit starts, set mid final stop bit.
    if (bit_edge && (pos_q == '0)) begin
      done_d = 1'b0;
    end else if (mid_edge && at_last) begin
      done_d = 1'b1;
    end

    // R9: a set event wins over a clear.
    if (set_evt) begin
      irq_d = 1'b1;
    end else if (irq_clr) begin
      irq_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      running_q <= 1'b0;
      frame_q   <= '1;
      pos_q     <= '0;
      nb_q      <= '0;
      done_q    <= 1'b1;
      irq_q     <= 1'b0;
    end else begin
      running_q <= running_d;
      frame_q   <= frame_d;
      pos_q     <= pos_d;
      nb_q      <= nb_d;
      done_q    <= done_d;
      irq_q     <= irq_d;
    end
  end

  assign txd        = running_q ? frame_q[0] : 1'b1;
  assign buf_empty  = ~buf_full;
  assign shift_done = done_q;
  assign irq_req    = irq_q;

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
  input logic clk,
  input logic rst_n_s,
  input logic tx_we,
  input logic irq_clr,
  input logic txd,
  input logic buf_empty,
  input logic shift_done,
  input logic irq_req
);

  // R2: a write always leaves the buffer occupied on the next cycle.
  a_r2_write_fills: assert property (@(posedge clk) disable iff (!rst_n_s)
    tx_we |=> !buf_empty);

  // R2: the buffer drains only when a start bit begins.
  a_r2_drain_starts_frame: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(buf_empty) |-> !txd);

  // R6: completion flag drops right after a start bit.
  a_r6_clear_after_start: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(shift_done) |-> $past(!txd));

  // R6: completion flag rises inside a stop bit.
  a_r6_set_in_stop: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(shift_done) |-> txd);

  // R9: the request only falls on a software clear.
  a_r9_drop_needs_clear: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(irq_req) |-> $past(irq_clr));

endmodule

bind sertx_core sertx_chk chk_i (
  .clk        (clk),
  .rst_n_s    (rst_n_s),
  .tx_we      (tx_we),
  .irq_clr    (irq_clr),
  .txd        (txd),
  .buf_empty  (buf_empty),
  .shift_done (shift_done),
  .irq_req    (irq_req)
);

// File: tb/sertx_core_tb_top.sv
`timescale 1ns/1ps
module sertx_core_tb_top;

  logic       clk;
  logic       rst_n;
  logic       baud_tick;
  logic       cfg_we, cfg_char8, cfg_par_en, cfg_par_odd, cfg_stop2, cfg_irq_done;
  logic       tx_we;
  logic [7:0] tx_wdata;
  logic       irq_clr;
  logic       txd, buf_empty, shift_done, irq_req;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // Bench copy of the settings.
  logic b_c8, b_pe, b_po, b_s2, b_src;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  sertx_core dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .cfg_we(cfg_we), .cfg_char8(cfg_char8), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_stop2(cfg_stop2), .cfg_irq_done(cfg_irq_done),
    .tx_we(tx_we), .tx_wdata(tx_wdata), .irq_clr(irq_clr),
    .txd(txd), .buf_empty(buf_empty), .shift_done(shift_done), .irq_req(irq_req)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int frame_len(input logic c8, input logic pe, input logic s2);
    return 1 + (c8 ? 8 : 7) + (pe ? 1 : 0) + (s2 ? 2 : 1);
  endfunction

  function automatic logic [11:0] frame_bits(input logic [7:0] d, input logic c8,
                                             input logic pe, input logic po);
    logic [11:0] v;
    int p, n, ones;
    v = '1;
    v[0] = 1'b0;
    p = 1;
    ones = 0;
    n = c8 ? 8 : 7;
    for (int i = 0; i < n; i++) begin
      v[p] = d[i];
      ones += int'(d[i]);
      p++;
    end
    if (pe) v[p] = po ? ((ones % 2) == 0) : ((ones % 2) == 1);
    return v;
  endfunction

  function automatic string bit_req(input int idx, input logic c8, input logic pe);
    int n;
    n = c8 ? 8 : 7;
    if (idx <= n) return "R3";
    if (pe && idx == n + 1) return "R4";
    return "R5";
  endfunction

  task automatic set_cfg(input logic c8, input logic pe, input logic po,
                         input logic s2, input logic src);
    cfg_char8 = c8; cfg_par_en = pe; cfg_par_odd = po; cfg_stop2 = s2;
    cfg_irq_done = src; cfg_we = 1'b1;
    b_c8 = c8; b_pe = pe; b_po = po; b_s2 = s2; b_src = src;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Write into an idle transmitter, clearing the interrupt on the load edge.
  task automatic start_idle(input logic [7:0] d);
    tx_wdata = d;
    tx_we = 1'b1;
    @(negedge clk);
    tx_we = 1'b0;
    irq_clr = 1'b1;
    check("R2", "buf_empty after write", 32'(buf_empty), 32'd0);
    check("R2", "txd before load", 32'(txd), 32'd1);
    @(negedge clk);
    irq_clr = 1'b0;
    check("R2", "start bit on load", 32'(txd), 32'd0);
    check("R2", "buf_empty after load", 32'(buf_empty), 32'd1);
    check("R9", "set vs clear on load", 32'(irq_req), 32'(!b_src));
  endtask

  // Follow one frame from its first start-bit cycle to its end.
  task automatic run_frame(input logic [7:0] d, input bit do_next, input logic [7:0] nxt,
                           input bit do_over, input logic [7:0] over_d,
                           input bit do_cfg, input logic [4:0] ncfg);
    logic [11:0] exp_v;
    int nb;
    logic c8, pe;
    exp_v = frame_bits(d, b_c8, b_pe, b_po);
    nb = frame_len(b_c8, b_pe, b_s2);
    c8 = b_c8;
    pe = b_pe;
    for (int k = 1; k <= 16 * nb; k++) begin
      @(negedge clk);
      tx_we = 1'b0; irq_clr = 1'b0; cfg_we = 1'b0;
      if (k == 2) irq_clr = 1'b1;
      if (k == 3) check("R9", "clear pulse", 32'(irq_req), 32'd0);
      if (do_next && k == 20) begin tx_we = 1'b1; tx_wdata = nxt; end
      if (do_next && k == 21) check("R2", "buf_empty mid frame", 32'(buf_empty), 32'd0);
      if (do_next && do_over && k == 36) begin tx_we = 1'b1; tx_wdata = over_d; end
      if (do_cfg && k == 50) begin
        cfg_char8 = ncfg[4]; cfg_par_en = ncfg[3]; cfg_par_odd = ncfg[2];
        cfg_stop2 = ncfg[1]; cfg_irq_done = ncfg[0]; cfg_we = 1'b1;
        b_c8 = ncfg[4]; b_pe = ncfg[3]; b_po = ncfg[2]; b_s2 = ncfg[1]; b_src = ncfg[0];
      end
      if (k % 16 == 8) begin
        int idx;
        idx = k / 16;
        check(bit_req(idx, c8, pe), $sformatf("bit %0d of %0h", idx, d),
              32'(txd), 32'(exp_v[idx]));
        if (idx == 1) check("R6", "done low at LSB", 32'(shift_done), 32'd0);
        if (idx == nb - 1) begin
          check("R6", "done high mid last stop", 32'(shift_done), 32'd1);
          check("R8", "request at completion", 32'(irq_req), 32'(b_src));
        end
      end
    end
    if (do_next) begin
      check("R7", "chained start bit", 32'(txd), 32'd0);
      check("R7", "buf_empty at chain load", 32'(buf_empty), 32'd1);
      check("R8", "request after chain", 32'(irq_req), 32'd1);
    end else begin
      check("R7", "line idle after frame", 32'(txd), 32'd1);
      check("R8", "request after idle end", 32'(irq_req), 32'(b_src));
    end
  endtask

  initial begin
    rst_n = 1'b1; baud_tick = 1'b1;
    cfg_we = 1'b0; cfg_char8 = 1'b1; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
    cfg_stop2 = 1'b0; cfg_irq_done = 1'b0;
    tx_we = 1'b0; tx_wdata = '0; irq_clr = 1'b0;
    b_c8 = 1'b1; b_pe = 1'b0; b_po = 1'b0; b_s2 = 1'b0; b_src = 1'b0;
    void'($urandom(32'h5eed_0042));
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "txd", 32'(txd), 32'd1);
    check("R1", "buf_empty", 32'(buf_empty), 32'd1);
    check("R1", "shift_done", 32'(shift_done), 32'd1);
    check("R1", "irq_req", 32'(irq_req), 32'd0);

    // Directed: 8N1, transfer-based interrupt.
    set_cfg(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    start_idle(8'hA5);
    run_frame(8'hA5, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 5'h0);

    // Directed: 7E2, completion interrupt, bit 7 dropped, chained byte
    // overwritten (R11), settings changed mid frame (R10).
    set_cfg(1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    start_idle(8'hFF);
    run_frame(8'hFF, 1'b1, 8'h3C, 1'b1, 8'h81, 1'b1, 5'b11100);
    run_frame(8'h81, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 5'h0);
    repeat (3) begin
      @(negedge clk);
      check("R7", "idle line", 32'(txd), 32'd1);
    end

    // Random mix.
    begin
      logic [7:0] cur;
      bit chained;
      chained = 0;
      cur = 8'($urandom);
      for (int f = 0; f < 40; f++) begin
        bit nx, ov, cf;
        logic [7:0] nd, od;
        nx = 1'($urandom_range(0, 1));
        ov = 1'($urandom_range(0, 1));
        cf = ($urandom_range(0, 3) == 0);
        nd = 8'($urandom);
        od = 8'($urandom);
        if (!chained) begin
          repeat ($urandom_range(1, 4)) @(negedge clk);
          if ($urandom_range(0, 1) == 1)
            set_cfg(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
          start_idle(cur);
        end
        run_frame(cur, nx, nd, ov, od, cf, 5'($urandom));
        chained = nx;
        cur = nx ? (ov ? od : nd) : 8'($urandom);
      end
      if (chained) run_frame(cur, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 5'h0);
    end

    repeat (4) @(negedge clk);
    check("R6", "done at rest", 32'(shift_done), 32'd1);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule